// File: doc/BRIEF.md
# Hourly Chime Tone Gate

This block drives a buzzer for the last ten seconds before each hour. It watches the clock's minute and second digits, which arrive as BCD. It also takes two square waves that are already running: a low tone at 512 Hz and a high tone at 1024 Hz. The block passes one of these tones, or nothing, to a single buzzer output.

While the time reads minute 59 and second 5x, the buzzer plays the low tone on the odd seconds 51, 53, 55 and 57. It plays the high tone on second 59, which marks the hour. The buzzer stays quiet on the even seconds in that range and at every other time. A mute input silences the chime completely.

The buzzer output comes from a flop on the system clock, so a glitch in the decode logic cannot reach the pin. The tone inputs must already be synchronous to that clock. All inputs are plain level signals with no handshake. The time digits are sampled on every clock edge, so there is no back-pressure and no valid/ready pairing.

Top module: `chime_gate`

## Requirements
- R1: While `rst_n` is low, `buzzer` is 0, and it goes to 0 as soon as reset is asserted, without waiting for a clock edge.
- R2: `buzzer` is registered. A change on any input appears on `buzzer` at the first rising clock edge after the change, and not before that edge.
- R3: The time digits are BCD values in the low four bits of each port: `min_tens` 0..5, `min_units` 0..9, `sec_tens` 0..5, `sec_units` 0..9. Unless `min_tens`=5, `min_units`=9 and `sec_tens`=5 all hold, `buzzer` is 0.
- R4: Inside that window with `chime_en`=1, a `sec_units` value of 1, 3, 5 or 7 makes `buzzer` follow `tone_lo`, with one cycle of delay.
- R5: Inside that window with `chime_en`=1, a `sec_units` value of 9 makes `buzzer` follow `tone_hi`, with one cycle of delay.
- R6: An even `sec_units` value (0, 2, 4, 6 or 8) makes `buzzer` 0, whatever the tone inputs and the window.
- R7: When `chime_en`=0, `buzzer` is 0 for every time value and tone level.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock; the tones are synchronous to it |
| rst_n | input | 1 | Asynchronous active-low reset |
| chime_en | input | 1 | 1 lets the chime sound; 0 mutes it |
| min_tens | input | 4 | BCD tens digit of the minutes |
| min_units | input | 4 | BCD units digit of the minutes |
| sec_tens | input | 4 | BCD tens digit of the seconds |
| sec_units | input | 4 | BCD units digit of the seconds |
| tone_lo | input | 1 | 512 Hz square wave |
| tone_hi | input | 1 | 1024 Hz square wave |
| buzzer | output | 1 | Gated tone, registered |

## Verification
The only state inside the block is the output flop. A fault in the decode or in that flop shows on `buzzer` one clock after the bad input pattern is applied: a tone where there should be silence, the wrong tone, or a missing tone. The bench applies every valid minute and second, with every combination of tone levels and enable, and checks the output one cycle later. Any decode error therefore appears at the first time value that triggers it. A latency fault is caught by sampling just before the capturing edge, and a reset fault is caught by asserting reset while the buzzer is sounding.

// File: rtl/chime_pkg.sv
package chime_pkg;
  // Digit values that place the time inside the pre-hour window.
  localparam int unsigned MARK_MIN_TENS  = 5;
  localparam int unsigned MARK_MIN_UNITS = 9;
  localparam int unsigned MARK_SEC_TENS  = 5;
  // Units-of-seconds value that carries the high-pitched mark.
  localparam int unsigned HIGH_SEC_UNITS = 9;

  typedef enum logic [1:0] {
    TONE_NONE = 2'd0,
    TONE_LOW  = 2'd1,
    TONE_HIGH = 2'd2
  } tone_sel_e;
endpackage

// File: rtl/chime_window_match.sv
// Decides whether the time lies in minute 59, seconds 50..59.
// FULL_DECODE=1 compares whole digits. FULL_DECODE=0 tests only the bits
// that separate the mark values among legal BCD codes (a smaller decode).
module chime_window_match #(
  parameter int unsigned DIGIT_W     = 4,
  parameter bit          FULL_DECODE = 1'b1
) (
  input  logic [DIGIT_W-1:0] min_tens,
  input  logic [DIGIT_W-1:0] min_units,
  input  logic [DIGIT_W-1:0] sec_tens,
  output logic               in_window
);
  import chime_pkg::*;

  generate
    if (FULL_DECODE) begin : g_full
      always_comb begin
        in_window = (min_tens  == DIGIT_W'(MARK_MIN_TENS))  &&
                    (min_units == DIGIT_W'(MARK_MIN_UNITS)) &&
                    (sec_tens  == DIGIT_W'(MARK_SEC_TENS));
      end
    end else begin : g_sparse
      always_comb begin
        in_window = min_units[0] & min_units[3] &
                    min_tens[0]  & min_tens[2]  &
                    sec_tens[0]  & sec_tens[2];
      end
    end
  endgenerate
endmodule

// File: rtl/chime_tone_select.sv
// Picks which tone (if any) the units-of-seconds digit calls for.
module chime_tone_select #(
  parameter int unsigned DIGIT_W     = 4,
  parameter bit          FULL_DECODE = 1'b1
) (
  input  logic [DIGIT_W-1:0]    sec_units,
  output chime_pkg::tone_sel_e  tone_sel
);
  import chime_pkg::*;

  localparam logic [DIGIT_W-1:0] HIGH_CODE = DIGIT_W'(HIGH_SEC_UNITS);

  generate
    if (FULL_DECODE) begin : g_full
      always_comb begin
        if (sec_units == HIGH_CODE)
          tone_sel = TONE_HIGH;
        else if (sec_units[0] && (sec_units < DIGIT_W'(8)))
          tone_sel = TONE_LOW;
        else
          tone_sel = TONE_NONE;
      end
    end else begin : g_sparse
      always_comb begin
        if (!sec_units[0])
          tone_sel = TONE_NONE;
        else if (sec_units[3])
          tone_sel = TONE_HIGH;
        else
          tone_sel = TONE_LOW;
      end
    end
  endgenerate
endmodule

// File: rtl/chime_out_reg.sv
// Output flop with asynchronous clear; removes decode glitches.
module chime_out_reg (
  input  logic clk,
  input  logic rst_n,
  input  logic d,
  output logic q
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) q <= 1'b0;
    else        q <= d;
  end
endmodule

// File: rtl/chime_gate.sv
module chime_gate #(
  parameter int unsigned DIGIT_W     = 4,
  parameter bit          FULL_DECODE = 1'b1
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               chime_en,
  input  logic [DIGIT_W-1:0] min_tens,
  input  logic [DIGIT_W-1:0] min_units,
  input  logic [DIGIT_W-1:0] sec_tens,
  input  logic [DIGIT_W-1:0] sec_units,
  input  logic               tone_lo,
  input  logic               tone_hi,
  output logic               buzzer
);
  import chime_pkg::*;

  logic      in_window;
  tone_sel_e tone_sel;
  logic      tone_pick;
  logic      buzz_next;

  chime_window_match #(.DIGIT_W(DIGIT_W), .FULL_DECODE(FULL_DECODE)) u_match (
    .min_tens  (min_tens),
    .min_units (min_units),
    .sec_tens  (sec_tens),
    .in_window (in_window)
  );

  chime_tone_select #(.DIGIT_W(DIGIT_W), .FULL_DECODE(FULL_DECODE)) u_select (
    .sec_units (sec_units),
    .tone_sel  (tone_sel)
  );

  always_comb begin
    unique case (tone_sel)
      TONE_LOW:  tone_pick = tone_lo;
      TONE_HIGH: tone_pick = tone_hi;
      default:   tone_pick = 1'b0;
    endcase
    buzz_next = chime_en & in_window & tone_pick;
  end

  chime_out_reg u_out (
    .clk   (clk),
    .rst_n (rst_n),
    .d     (buzz_next),
    .q     (buzzer)
  );
endmodule

// File: rtl/chime_gate_checker.sv
module chime_gate_checker #(
  parameter int unsigned DIGIT_W = 4
) (
  input logic               clk,
  input logic               rst_n,
  input logic               chime_en,
  input logic [DIGIT_W-1:0] min_tens,
  input logic [DIGIT_W-1:0] min_units,
  input logic [DIGIT_W-1:0] sec_tens,
  input logic [DIGIT_W-1:0] sec_units,
  input logic               tone_lo,
  input logic               tone_hi,
  input logic               buzzer
);
  logic legal_bcd;
  logic window;
  logic odd_low;
  assign legal_bcd = (min_tens <= DIGIT_W'(5)) && (min_units <= DIGIT_W'(9)) &&
                     (sec_tens <= DIGIT_W'(5)) && (sec_units <= DIGIT_W'(9));
  assign window    = (min_tens == DIGIT_W'(5)) && (min_units == DIGIT_W'(9)) &&
                     (sec_tens == DIGIT_W'(5));
  assign odd_low   = (sec_units == DIGIT_W'(1)) || (sec_units == DIGIT_W'(3)) ||
                     (sec_units == DIGIT_W'(5)) || (sec_units == DIGIT_W'(7));

  AST_RESET_QUIET: assert property (@(negedge clk) !rst_n |-> !buzzer); // R1
  AST_MUTE: assert property (@(posedge clk) disable iff (!rst_n)
    !chime_en |=> !buzzer); // R7
  AST_OUTSIDE: assert property (@(posedge clk) disable iff (!rst_n)
    (legal_bcd && !window) |=> !buzzer); // R3
  AST_EVEN_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    !sec_units[0] |=> !buzzer); // R6
  AST_LOW_TONE: assert property (@(posedge clk) disable iff (!rst_n)
    (chime_en && window && odd_low) |=> (buzzer == $past(tone_lo))); // R4
  AST_HIGH_TONE: assert property (@(posedge clk) disable iff (!rst_n)
    (chime_en && window && sec_units == DIGIT_W'(9)) |=> (buzzer == $past(tone_hi))); // R5
endmodule

bind chime_gate chime_gate_checker #(.DIGIT_W(DIGIT_W)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .chime_en  (chime_en),
  .min_tens  (min_tens),
  .min_units (min_units),
  .sec_tens  (sec_tens),
  .sec_units (sec_units),
  .tone_lo   (tone_lo),
  .tone_hi   (tone_hi),
  .buzzer    (buzzer)
);

// File: tb/chime_gate_bench.sv
`timescale 1ns/1ps
module chime_gate_bench;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       chime_en = 1'b0;
  logic [3:0] min_tens = '0, min_units = '0, sec_tens = '0, sec_units = '0;
  logic       tone_lo = 1'b0, tone_hi = 1'b0;
  logic       buzzer;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #10 clk = ~clk; // 50 MHz

  chime_gate u_chime_gate (
    .clk(clk), .rst_n(rst_n), .chime_en(chime_en),
    .min_tens(min_tens), .min_units(min_units),
    .sec_tens(sec_tens), .sec_units(sec_units),
    .tone_lo(tone_lo), .tone_hi(tone_hi), .buzzer(buzzer)
  );

  task automatic check(input string req, input logic act, input logic exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: time %0d%0d:%0d%0d en=%0b lo=%0b hi=%0b buzzer=%0b expected=%0b",
               req, min_tens, min_units, sec_tens, sec_units,
               chime_en, tone_lo, tone_hi, act, exp);
    end
  endtask

  task automatic drive(input int mm, input int ss, input bit en, input bit lo, input bit hi);
    min_tens  = 4'(mm / 10);
    min_units = 4'(mm % 10);
    sec_tens  = 4'(ss / 10);
    sec_units = 4'(ss % 10);
    chime_en  = en;
    tone_lo   = lo;
    tone_hi   = hi;
  endtask

  initial begin
    // R1: reset state, with inputs that would otherwise sound the high tone
    drive(59, 59, 1'b1, 1'b1, 1'b1);
    repeat (3) @(negedge clk);
    check("R1", buzzer, 1'b0);
    rst_n = 1'b1;

    // R2: the output changes only at the capturing edge
    @(negedge clk);
    check("R2", buzzer, 1'b1);
    drive(59, 59, 1'b1, 1'b1, 1'b0);
    #5;
    check("R2", buzzer, 1'b1);
    @(negedge clk);
    check("R2", buzzer, 1'b0);
    drive(59, 57, 1'b1, 1'b1, 1'b0);
    #5;
    check("R2", buzzer, 1'b0);
    @(negedge clk);
    check("R4", buzzer, 1'b1);

    // R1: asynchronous clear while sounding
    #3 rst_n = 1'b0;
    #1 check("R1", buzzer, 1'b0);
    @(negedge clk);
    check("R1", buzzer, 1'b0);
    rst_n = 1'b1;

    // Sweep every legal time, tone level pair and enable value
    for (int en = 0; en < 2; en++) begin
      for (int mm = 0; mm < 60; mm++) begin
        for (int ss = 0; ss < 60; ss++) begin
          for (int t = 0; t < 4; t++) begin
            bit    lo, hi, win, expv;
            int    u;
            string req;
            lo  = t[0];
            hi  = t[1];
            u   = ss % 10;
            win = (mm == 59) && (ss / 10 == 5);
            if (en == 0)              begin req = "R7"; expv = 1'b0; end
            else if (!win)            begin req = "R3"; expv = 1'b0; end
            else if (u % 2 == 0)      begin req = "R6"; expv = 1'b0; end
            else if (u == 9)          begin req = "R5"; expv = hi;   end
            else                      begin req = "R4"; expv = lo;   end
            @(negedge clk);
            drive(mm, ss, en[0], lo, hi);
            @(negedge clk);
            check(req, buzzer, expv);
          end
        end
      end
    end
    done = 1'b1;
  end

  initial begin
    int cyc = 0;
    while (!done && cyc < 150000) begin
      @(posedge clk);
      cyc++;
    end
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: run did not finish, buzzer=%0b expected=done", buzzer);
    end
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule